// File: doc/BRIEF.md
# DAC Output Update Controller

This block decides when the output code register of an 18-bit DAC takes a new value. The serial port hands it committed writes, and each write is steered either to the staging (input) register or to the clear-code register. Four active-low pins are synchronised into the system clock domain: frame select, load, clear and hardware reset. Software clear and software reset strobes arrive as one-cycle pulses. The block holds three registers: staging, clear code and output. It presents the output register as `dac_code`.

The load pin level during a frame picks the update mode. If load stays low for the whole frame, the output takes the written value when the frame's write is committed. If load is high at any point in the frame, the commit only fills the staging register. The output then follows on a later falling edge of load that arrives while frame select is high. A qualified clear forces the output to the clear code and blocks every load while it lasts. A reset from the pin or from software zeroes all three registers.

Top module: `dac_update_ctrl`

## Requirements
- R1: After `rst_n` deasserts, the output, staging and clear-code registers all read zero.
- R2: A write with `wr_sel`=0 sets the output to `wr_data` on the next clock if `load_n` stayed low for the whole frame (`frame_n` low). The frame flag is judged from the synchronised pins.
- R3: If the synchronised `load_n` was high at any point while `frame_n` was low, the commit leaves the output unchanged. A later high-to-low transition of `load_n` while `frame_n` is high copies the staging register to the output. This happens SYNC_STAGES+1 clocks after the pin falls.
- R4: A falling `load_n` while `frame_n` is low does not change the output.
- R5: A repeated `load_n` falling edge with no new staging write reloads the same value.
- R6: Holding `clear_n` low for at least CLR_MIN synchronised clocks forces the output to the clear code, and the output stays there while the pin stays low.
- R7: A `clear_n` low pulse shorter than CLR_MIN synchronised clocks has no effect on the output.
- R8: While a clear is active, neither a commit nor a `load_n` falling edge changes the output. Staging writes are still captured.
- R9: After `clear_n` returns high, the output keeps the clear code until the next load.
- R10: A one-cycle `sw_clear` loads the clear code into the output on the next clock. It wins over a commit in the same cycle, and that commit still fills the staging register.
- R11: Low synchronised `hwrst_n` or a `sw_reset` strobe zeroes all three registers on the next clock. It wins over any write in the same cycle.
- R12: A write with `wr_sel`=1 goes to the clear-code register and does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| frame_n | input | 1 | Serial frame select pin, low during a frame |
| load_n | input | 1 | Load pin, active low |
| clear_n | input | 1 | Clear pin, active low, minimum width filtered |
| hwrst_n | input | 1 | Hardware reset pin, active low |
| wr_valid | input | 1 | One-cycle commit strobe from the serial port |
| wr_sel | input | 1 | Write target: 0 staging register, 1 clear-code register |
| wr_data | input | 18 | Committed write data |
| sw_clear | input | 1 | Software clear strobe, one cycle |
| sw_reset | input | 1 | Software reset strobe, one cycle |
| dac_code | output | 18 | Output code register |

## Verification
The collision of most interest is a software clear landing in the same cycle as a synchronous commit. The bench raises `sw_clear` together with `wr_valid`. It expects the clear code on the output and the new data in the staging register, and a later load edge exposes the staging value. A second overlap occurs when the clear pin is held through a complete frame and through a load edge. A cycle-accurate behavioural model compared on every clock judges the exact cycle of every change, and directed constant checks confirm the final values.

// File: rtl/duc_pkg.sv
package duc_pkg;

    parameter int unsigned CODE_W = 18;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic {
        TGT_INPUT   = 1'b0,
        TGT_CLRCODE = 1'b1
    } wr_tgt_e;

    typedef struct packed {
        code_t inp;
        code_t clr_code;
        code_t dac;
    } dac_regs_t;

    typedef struct packed {
        logic frame_prev;
        logic load_prev;
        logic async_seen;
    } mode_st_t;

    localparam int unsigned PIN_FRAME = 0;
    localparam int unsigned PIN_LOAD  = 1;
    localparam int unsigned PIN_CLEAR = 2;
    localparam int unsigned PIN_HWRST = 3;
    localparam int unsigned NUM_PINS  = 4;

endpackage

// File: rtl/duc_pin_sync.sv
// Multi-stage synchroniser for active-low pins; idles high in reset.
// STAGES must be at least 2.
module duc_pin_sync #(
    parameter int unsigned NPINS  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_i,
    output logic [NPINS-1:0] pins_o
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], pins_i[p]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign pins_o[p] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/duc_clear_filter.sv
// Qualifies the synchronised clear pin: active only after MIN_LOW
// consecutive low cycles.
module duc_clear_filter #(
    parameter int unsigned MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n_s,
    output logic clr_active
);

    localparam int unsigned      CNT_W   = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_LOW - 1);

    logic [CNT_W-1:0] run_d, run_q;

    always_comb begin
        if (clear_n_s)             run_d = '0;
        else if (run_q == CNT_TOP) run_d = run_q;
        else                       run_d = run_q + CNT_W'(1);
        clr_active = !clear_n_s && (run_q == CNT_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    if (MIN_LOW >= 2) begin : g_chk
        // R7: a qualified clear implies the pin was already low last cycle
        p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_active |-> (!clear_n_s && !$past(clear_n_s)));
    end

endmodule

// File: rtl/duc_frame_mode.sv
// Tracks whether the load pin was high during the current frame and
// detects load falling edges outside a frame.
module duc_frame_mode
    import duc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n_s,
    input  logic load_n_s,
    output logic async_frame,
    output logic load_fall
);

    mode_st_t st_d, st_q;
    logic     frame_start;
    logic     high_in_frame;

    always_comb begin
        frame_start         = st_q.frame_prev && !frame_n_s;
        high_in_frame       = !frame_n_s && load_n_s;
        st_d.frame_prev     = frame_n_s;
        st_d.load_prev      = load_n_s;
        st_d.async_seen     = (frame_start ? 1'b0 : st_q.async_seen) || high_in_frame;
        load_fall           = st_q.load_prev && !load_n_s && frame_n_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{frame_prev: 1'b1, load_prev: 1'b1, async_seen: 1'b0};
        else        st_q <= st_d;
    end

    assign async_frame = st_q.async_seen;

    // R3: load high inside a frame marks the frame asynchronous
    p_async_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n_s && load_n_s) |=> async_frame);

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import duc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLR_MIN     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              load_n,
    input  logic              clear_n,
    input  logic              hwrst_n,
    input  logic              wr_valid,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              sw_clear,
    input  logic              sw_reset,
    output logic [CODE_W-1:0] dac_code
);

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_s;
    logic                clr_active;
    logic                async_frame;
    logic                load_fall;

    assign pins_raw = {hwrst_n, clear_n, load_n, frame_n};

    duc_pin_sync #(
        .NPINS  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_raw),
        .pins_o (pins_s)
    );

    duc_clear_filter #(
        .MIN_LOW (CLR_MIN)
    ) u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_n_s  (pins_s[PIN_CLEAR]),
        .clr_active (clr_active)
    );

    duc_frame_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n_s   (pins_s[PIN_FRAME]),
        .load_n_s    (pins_s[PIN_LOAD]),
        .async_frame (async_frame),
        .load_fall   (load_fall)
    );

    dac_regs_t regs_d, regs_q;
    logic      reset_any;
    logic      clear_any;
    logic      wr_input;
    logic      wr_code;
    logic      commit_load;

    // Priority: reset > clear > synchronous commit > load edge
    always_comb begin
        reset_any   = !pins_s[PIN_HWRST] || sw_reset;
        clear_any   = clr_active || sw_clear;
        wr_input    = wr_valid && (wr_tgt_e'(wr_sel) == TGT_INPUT);
        wr_code     = wr_valid && (wr_tgt_e'(wr_sel) == TGT_CLRCODE);
        commit_load = wr_input && !async_frame;

        regs_d = regs_q;
        if (reset_any) begin
            regs_d = '0;
        end else begin
            if (wr_input) regs_d.inp      = wr_data;
            if (wr_code)  regs_d.clr_code = wr_data;
            if (clear_any)        regs_d.dac = regs_q.clr_code;
            else if (commit_load) regs_d.dac = wr_data;
            else if (load_fall)   regs_d.dac = regs_q.inp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dac_code = regs_q.dac;

    // R11: any reset source zeroes the output on the next clock
    p_reset_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reset_any |=> (dac_code == '0));

    // R8: an active clear drives the stored clear code, blocking loads
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_any && !reset_any) |=> (dac_code == $past(regs_q.clr_code)));

    // R9: without any load, clear or reset the output holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!reset_any && !clear_any && !commit_load && !load_fall) |=> $stable(dac_code));

    // R2: a synchronous commit lands on the output one clock later
    p_sync_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_load && !clear_any && !reset_any) |=> (dac_code == $past(wr_data)));

endmodule

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb_top;

    localparam int W      = 18;
    localparam int CLRMIN = 2;

    logic         clk      = 1'b0;
    logic         rst_n    = 1'b0;
    logic         frame_n  = 1'b1;
    logic         load_n   = 1'b1;
    logic         clear_n  = 1'b1;
    logic         hwrst_n  = 1'b1;
    logic         wr_valid = 1'b0;
    logic         wr_sel   = 1'b0;
    logic [W-1:0] wr_data  = '0;
    logic         sw_clear = 1'b0;
    logic         sw_reset = 1'b0;
    logic [W-1:0] dac_code;

    always #5 clk = ~clk;

    dac_update_ctrl #(.SYNC_STAGES(2), .CLR_MIN(CLRMIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .load_n(load_n),
        .clear_n(clear_n), .hwrst_n(hwrst_n), .wr_valid(wr_valid),
        .wr_sel(wr_sel), .wr_data(wr_data), .sw_clear(sw_clear),
        .sw_reset(sw_reset), .dac_code(dac_code)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 1'b0;

    // Behavioural reference: pin history, frame flag, clear run length
    logic [3:0]   m_s1, m_s2;   // bit 0 frame, 1 load, 2 clear, 3 hwrst
    logic         m_fprev, m_lprev, m_async;
    int           m_run;
    logic [W-1:0] m_inp, m_code, m_dac;

    always @(posedge clk or negedge rst_n) begin : model
        logic         rst_hit, clr_on, fall, sync_ld, n_async;
        logic [W-1:0] n_inp, n_code, n_dac;
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_fprev = 1'b1; m_lprev = 1'b1;
            m_async = 1'b0; m_run = 0; m_inp = '0; m_code = '0; m_dac = '0;
        end else begin
            rst_hit = !m_s2[3] || sw_reset;
            clr_on  = !m_s2[2] && (m_run >= CLRMIN - 1);
            fall    = m_lprev && !m_s2[1] && m_s2[0];
            sync_ld = wr_valid && !wr_sel && !m_async;
            n_inp = m_inp; n_code = m_code; n_dac = m_dac;
            if (rst_hit) begin
                n_inp = '0; n_code = '0; n_dac = '0;
            end else begin
                if (wr_valid && !wr_sel) n_inp  = wr_data;
                if (wr_valid &&  wr_sel) n_code = wr_data;
                if (clr_on || sw_clear) n_dac = m_code;
                else if (sync_ld)       n_dac = wr_data;
                else if (fall)          n_dac = m_inp;
            end
            n_async = ((m_fprev && !m_s2[0]) ? 1'b0 : m_async) || (!m_s2[0] && m_s2[1]);
            if (m_s2[2]) m_run = 0;
            else if (m_run < CLRMIN - 1) m_run = m_run + 1;
            m_fprev = m_s2[0];
            m_lprev = m_s2[1];
            m_async = n_async;
            m_s2 = m_s1;
            m_s1 = {hwrst_n, clear_n, load_n, frame_n};
            m_inp = n_inp; m_code = n_code; m_dac = n_dac;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (dac_code !== m_dac) begin
                n_fail++;
                $display("FAIL %s per-clock: dac_code=%05h expected %05h", phase, dac_code, m_dac);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (dac_code !== exp) begin
            n_fail++;
            $display("FAIL %s: dac_code=%05h expected %05h", req, dac_code, exp);
        end
    endtask

    task automatic frame(input logic [W-1:0] data, input logic sel, input logic load_level);
        frame_n = 1'b0; load_n = load_level;
        tick(4);
        frame_n = 1'b1;
        tick(3);
        wr_valid = 1'b1; wr_sel = sel; wr_data = data;
        tick(1);
        wr_valid = 1'b0;
        tick(3);
    endtask

    task automatic pulse_load();
        load_n = 1'b1;
        tick(3);
        load_n = 1'b0;
        tick(5);
    endtask

    task automatic pulse_swclr();
        sw_clear = 1'b1;
        tick(1);
        sw_clear = 1'b0;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        phase = "R1"; check("R1 reset output", '0);
        pulse_swclr(); check("R1 clear code zero", '0);
        pulse_load();  check("R1 staging zero", '0);

        phase = "R12"; frame(18'h2AAAA, 1'b1, 1'b0); check("R12 code write no output", '0);
        phase = "R2";  frame(18'h12345, 1'b0, 1'b0); check("R2 sync commit", 18'h12345);

        phase = "R3";  frame(18'h0BEEF, 1'b0, 1'b1); check("R3 async commit holds", 18'h12345);
        pulse_load();  check("R3 load edge", 18'h0BEEF);
        phase = "R5";  pulse_load(); check("R5 reload same", 18'h0BEEF);

        phase = "R4";  frame(18'h3FFFF, 1'b0, 1'b1); check("R4 async commit holds", 18'h0BEEF);
        frame_n = 1'b0; tick(4);
        load_n = 1'b0;  tick(4); check("R4 edge inside frame", 18'h0BEEF);
        load_n = 1'b1; frame_n = 1'b1; tick(4);
        load_n = 1'b0; tick(5); check("R3 edge after frame", 18'h3FFFF);

        phase = "R7";  clear_n = 1'b0; tick(1); clear_n = 1'b1; tick(5);
        check("R7 short clear ignored", 18'h3FFFF);
        phase = "R6";  clear_n = 1'b0; tick(2); clear_n = 1'b1; tick(5);
        check("R6 minimum clear width", 18'h2AAAA);
        pulse_load(); check("R9 load after short clear", 18'h3FFFF);
        clear_n = 1'b0; tick(6); check("R6 clear held", 18'h2AAAA);

        phase = "R8";  frame(18'h00111, 1'b0, 1'b0); check("R8 commit blocked", 18'h2AAAA);
        pulse_load(); check("R8 load edge blocked", 18'h2AAAA);
        phase = "R9";  clear_n = 1'b1; tick(6); check("R9 hold after release", 18'h2AAAA);
        pulse_load(); check("R9 staged value loads", 18'h00111);

        phase = "R10";
        frame_n = 1'b0; load_n = 1'b0; tick(4);
        frame_n = 1'b1; tick(3);
        wr_valid = 1'b1; wr_sel = 1'b0; wr_data = 18'h15555; sw_clear = 1'b1;
        tick(1);
        wr_valid = 1'b0; sw_clear = 1'b0;
        tick(3); check("R10 sw clear beats commit", 18'h2AAAA);
        pulse_load(); check("R10 staging kept", 18'h15555);

        phase = "R11";
        sw_reset = 1'b1; wr_valid = 1'b1; wr_sel = 1'b1; wr_data = 18'h00003;
        tick(1);
        sw_reset = 1'b0; wr_valid = 1'b0;
        tick(2); check("R11 sw reset output", '0);
        pulse_swclr(); check("R11 reset beats code write", '0);
        frame(18'h00777, 1'b0, 1'b0); check("R11 load after reset", 18'h00777);
        hwrst_n = 1'b0; tick(4); check("R11 pin reset", '0);
        hwrst_n = 1'b1; tick(4); check("R11 after pin release", '0);
        pulse_load(); check("R11 staging cleared", '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: state=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule